// File: doc/BRIEF.md
# PWM Sample FIFO Control Register

This block is the control and status register of an audio or tone pulse-width modulator. A CPU reaches it over a simple 16-bit bus with read and write strobes and one select line. The select line picks either the control word or the sample port. The control word holds a clock-source choice, a 7-bit divider, an interrupt flag and an interrupt enable. It also shows a read-only bit that tells software whether the sample queue can take another word.

Each write to the sample port carries two sample bytes and lands in a four-byte queue. The modulator's period-end strobe takes one byte from the queue at a time. When the queue drops to one byte or none, the interrupt flag rises so that software can refill it with at most two words. A read of the control word clears the flag as a side effect. The divider turns the chosen incoming clock strobe into a tick every (value+1) source strobes. The compare stage and the clock generators are outside this block and appear only as strobes.

Top module: `pwm_ctl_top`

## Requirements
- R1: While reset is held and straight after it, a control-word read returns 0x0020, the interrupt output is 0, and no sample is valid.
- R2: Control bit 15 selects the divider's source strobe: 0 takes `sysTick`, 1 takes `slowTick`. Reset value is 0.
- R3: Control bits 14:8 hold the divider value N (0 to 127). `prescTick` pulses in the same cycle as every (N+1)th selected source strobe. A control write that changes N restarts the count, so the first tick after it comes on the (N+1)th source strobe. A write that leaves N unchanged does not restart the count.
- R4: Control bit 7 is the interrupt flag. It is set in the cycle after any cycle in which the queue holds one byte or none.
- R5: A control-word read clears the flag in the next cycle. If the queue is at one byte or fewer in the cycle of the read, the set wins and the flag stays 1.
- R6: A control write with bit 7 = 1 sets the flag in the next cycle. A write with bit 7 = 0 never clears it.
- R7: Control bit 6 enables the interrupt. `irqOut` equals flag AND enable, and the flag can still be read while the enable is 0.
- R8: Control bit 5 reads 1 exactly when the queue holds two bytes or fewer. Bits 5:0 ignore writes, and bits 4:0 read 0. A read with `regSel` = 1 returns 0.
- R9: A write with `regSel` = 1 stores `wrData[15:8]` and then `wrData[7:0]`, in that order, into the four-byte queue. If the queue holds more than two bytes, the whole write is dropped.
- R10: A `periodEnd` strobe removes the oldest byte. `sampleByte` shows the oldest byte while `sampleValid` is 1, and shows 0 when the queue is empty. A strobe on an empty queue has no effect.
- R11: A sample write and a `periodEnd` pop in the same cycle both take effect. The pop removes the oldest byte and the level changes by +1. Whether the write is accepted depends only on the level at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0 = control word, 1 = sample port |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational) |
| periodEnd | input | 1 | Period-end strobe from the compare stage; pops one byte |
| sysTick | input | 1 | System clock-enable strobe |
| slowTick | input | 1 | Low-frequency clock-enable strobe |
| prescTick | output | 1 | Divided tick |
| sampleByte | output | 8 | Oldest queued byte |
| sampleValid | output | 1 | Queue is not empty |
| irqOut | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the flag's clear-on-read against its low-water set. The bench reads the control word once while the queue holds four bytes, where the flag must drop in the next cycle. It reads again while the queue holds one byte or none, where the flag must stay 1.

The second pair is a sample write against a period-end pop. The bench strikes both together at levels of two and one bytes and checks the level, the byte order and the fill bit against a queue-based model. A long random phase then mixes reads, software sets, writes and pops, and the model is compared on every clock.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
  localparam int CTL_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int PRESC_W   = 7;
  localparam int BIT_SRC   = 15;
  localparam int PRESC_LO  = 8;
  localparam int BIT_FLAG  = 7;
  localparam int BIT_EN    = 6;
  localparam int BIT_ROOM  = 5;

  // strobes from the register/control side to the queue and divider datapath
  typedef struct packed {
    logic pushReq;
    logic popReq;
    logic prescRestart;
  } dpStrobe_t;
endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
  import pwm_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [CTL_W-1:0]    wrData,
  input  logic                periodEnd,
  input  logic [LVL_W-1:0]    fifoLevel,
  output dpStrobe_t           strobe,
  output logic                clkSrcSel,
  output logic [PRESC_W-1:0]  prescVal,
  output logic [CTL_W-1:0]    rdData,
  output logic                irqOut
);
  localparam logic [LVL_W-1:0] LOW_MARK  = LVL_W'(1);
  localparam logic [LVL_W-1:0] ROOM_MARK = LVL_W'(FIFO_DEPTH - 2);

  logic srcReg, flagReg, enReg;
  logic [PRESC_W-1:0] prescReg;
  logic ctlWr, ctlRd, smpWr, lowWater, roomForWord, swPost, flagNext;
  logic [PRESC_W-1:0] prescWr;

  assign ctlWr       = wrEn & ~regSel;
  assign smpWr       = wrEn & regSel;
  assign ctlRd       = rdEn & ~regSel;
  assign lowWater    = fifoLevel <= LOW_MARK;
  assign roomForWord = fifoLevel <= ROOM_MARK;
  assign swPost      = ctlWr & wrData[BIT_FLAG];
  assign prescWr     = wrData[PRESC_LO +: PRESC_W];

  assign strobe.pushReq      = smpWr & roomForWord;
  assign strobe.popReq       = periodEnd & (fifoLevel != '0);
  assign strobe.prescRestart = ctlWr & (prescWr != prescReg);

  // set (low water or software post) outranks clear-on-read
  always_comb begin
    if (lowWater || swPost) flagNext = 1'b1;
    else if (ctlRd)         flagNext = 1'b0;
    else                    flagNext = flagReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= 1'b0;
      prescReg <= '0;
      enReg    <= 1'b0;
      flagReg  <= 1'b0;
    end else begin
      flagReg <= flagNext;
      if (ctlWr) begin
        srcReg   <= wrData[BIT_SRC];
        prescReg <= prescWr;
        enReg    <= wrData[BIT_EN];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (!regSel) begin
      rdData[BIT_SRC]                 = srcReg;
      rdData[PRESC_LO +: PRESC_W]     = prescReg;
      rdData[BIT_FLAG]                = flagReg;
      rdData[BIT_EN]                  = enReg;
      rdData[BIT_ROOM]                = roomForWord;
    end
  end

  assign clkSrcSel = srcReg;
  assign prescVal  = prescReg;
  assign irqOut    = flagReg & enReg;

  a_r4_low_sets: assert property (@(posedge clk) disable iff (!rstN)
    lowWater |=> flagReg);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRd && !lowWater && !swPost) |=> !flagReg);
  a_r6_sw_post: assert property (@(posedge clk) disable iff (!rstN)
    swPost |=> flagReg);
  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !ctlRd) |=> flagReg);
endmodule

// File: rtl/pwm_ctl_data.sv
module pwm_ctl_data
  import pwm_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [CTL_W-1:0]    pushWord,
  input  logic                clkSrcSel,
  input  logic [PRESC_W-1:0]  prescVal,
  input  logic                sysTick,
  input  logic                slowTick,
  output logic [LVL_W-1:0]    fifoLevel,
  output logic [BYTE_W-1:0]   sampleByte,
  output logic                sampleValid,
  output logic                prescTick
);
  // depth must be a power of two so the pointers wrap naturally
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [BYTE_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrLo;
  logic [PRESC_W-1:0] prescCnt;
  logic srcTick, cntHit;

  assign wrPtrLo = wrPtr + PTR_W'(1);

  genvar g;
  generate
    for (g = 0; g < FIFO_DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobe.pushReq) begin
          if (wrPtr == PTR_W'(g))        mem[g] <= pushWord[CTL_W-1:BYTE_W];
          else if (wrPtrLo == PTR_W'(g)) mem[g] <= pushWord[BYTE_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (strobe.pushReq) wrPtr <= wrPtr + PTR_W'(2);
      if (strobe.popReq)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strobe.pushReq, strobe.popReq})
        2'b10:   fifoLevel <= fifoLevel + LVL_W'(2);
        2'b11:   fifoLevel <= fifoLevel + LVL_W'(1);
        2'b01:   fifoLevel <= fifoLevel - LVL_W'(1);
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  assign sampleValid = fifoLevel != '0;
  assign sampleByte  = sampleValid ? mem[rdPtr] : '0;

  // divider: tick on every (prescVal+1)th selected source strobe
  assign srcTick   = clkSrcSel ? slowTick : sysTick;
  assign cntHit    = prescCnt == prescVal;
  assign prescTick = srcTick & cntHit;

  always_ff @(posedge clk) begin
    if (!rstN)                    prescCnt <= '0;
    else if (strobe.prescRestart) prescCnt <= '0;
    else if (srcTick)             prescCnt <= cntHit ? '0 : prescCnt + PRESC_W'(1);
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(FIFO_DEPTH));
  a_r9_push_adds_two: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushReq && !strobe.popReq) |=> fifoLevel == $past(fifoLevel) + LVL_W'(2));
  a_r10_empty_pop_noop: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == '0 && !strobe.pushReq) |=> fifoLevel == '0);
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= prescVal);
endmodule

// File: rtl/pwm_ctl_top.sv
module pwm_ctl_top
  import pwm_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [15:0]        wrData,
  output logic [15:0]        rdData,
  input  logic               periodEnd,
  input  logic               sysTick,
  input  logic               slowTick,
  output logic               prescTick,
  output logic [7:0]         sampleByte,
  output logic               sampleValid,
  output logic               irqOut
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t          strobe;
  logic [LVL_W-1:0]   fifoLevel;
  logic               clkSrcSel;
  logic [PRESC_W-1:0] prescVal;

  pwm_ctl_regs #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) regs_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .periodEnd(periodEnd), .fifoLevel(fifoLevel),
    .strobe(strobe), .clkSrcSel(clkSrcSel), .prescVal(prescVal),
    .rdData(rdData), .irqOut(irqOut)
  );

  pwm_ctl_data #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushWord(wrData),
    .clkSrcSel(clkSrcSel), .prescVal(prescVal), .sysTick(sysTick),
    .slowTick(slowTick), .fifoLevel(fifoLevel), .sampleByte(sampleByte),
    .sampleValid(sampleValid), .prescTick(prescTick)
  );
endmodule

// File: tb/pwm_ctl_top_tb_top.sv
module pwm_ctl_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, periodEnd = 1'b0;
  logic sysTick = 1'b0, slowTick = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic prescTick, sampleValid, irqOut;
  logic [7:0] sampleByte;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  logic [7:0] q[$];
  bit mFlag = 0, mEn = 0, mSrc = 0;
  int mPresc = 0, mCnt = 0;

  always #10 clk = ~clk;

  pwm_ctl_top dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .periodEnd(periodEnd),
    .sysTick(sysTick), .slowTick(slowTick), .prescTick(prescTick),
    .sampleByte(sampleByte), .sampleValid(sampleValid), .irqOut(irqOut)
  );

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  function automatic int expCtl();
    int v;
    v = (int'(mSrc) << 15) | (mPresc << 8) | (int'(mFlag) << 7) | (int'(mEn) << 6);
    if (q.size() <= 2) v |= 32'h20;
    return v;
  endfunction

  function automatic bit srcNow();
    return mSrc ? slowTick : sysTick;
  endfunction

  task automatic compareAll();
    cmp("rdData", rdData, regSel ? 0 : expCtl());
    cmp("irqOut", irqOut, mFlag & mEn);
    cmp("sampleValid", sampleValid, q.size() > 0);
    cmp("sampleByte", sampleByte, q.size() > 0 ? q[0] : 0);
    cmp("prescTick", prescTick, srcNow() && (mCnt == mPresc));
  endtask

  task automatic modelUpdate();
    bit low, push, pop, sw, rd, ctlWr, tick;
    int newPresc;
    low   = q.size() <= 1;
    push  = wrEn && regSel && q.size() <= 2;
    pop   = periodEnd && q.size() > 0;
    ctlWr = wrEn && !regSel;
    sw    = ctlWr && wrData[7];
    rd    = rdEn && !regSel;
    tick  = srcNow();
    if (tick) mCnt = (mCnt == mPresc) ? 0 : mCnt + 1;
    if (pop) void'(q.pop_front());
    if (push) begin
      q.push_back(wrData[15:8]);
      q.push_back(wrData[7:0]);
    end
    if (low || sw) mFlag = 1;
    else if (rd)   mFlag = 0;
    if (ctlWr) begin
      newPresc = int'(wrData[14:8]);
      if (newPresc != mPresc) mCnt = 0;
      mPresc = newPresc;
      mSrc   = wrData[15];
      mEn    = wrData[6];
    end
  endtask

  // one clock: compare away from the edge, then advance the model at the edge
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic idle();
    regSel = 0; wrEn = 0; rdEn = 0; periodEnd = 0; sysTick = 0; slowTick = 0; wrData = '0;
  endtask

  task automatic wrCtl(logic [15:0] d);
    idle(); regSel = 0; wrEn = 1; wrData = d; step(); idle();
  endtask
  task automatic wrSmp(logic [15:0] d);
    idle(); regSel = 1; wrEn = 1; wrData = d; step(); idle();
  endtask
  task automatic rdCtl();
    idle(); rdEn = 1; step(); idle();
  endtask
  task automatic popOne();
    idle(); periodEnd = 1; step(); idle();
  endtask
  task automatic idleN(int n);
    idle();
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state seen while reset is held
    curReq = "R1";
    for (int i = 0; i < 3; i++) begin
      #1;
      cmp("rdData in reset", rdData, 16'h0020);
      cmp("irqOut in reset", irqOut, 0);
      cmp("sampleValid in reset", sampleValid, 0);
      @(negedge clk);
    end
    rstN = 1;
    idleN(3);

    // R9: order high then low, overflow drop; R8 room bit follows level
    curReq = "R9";
    wrSmp(16'hA1B2);
    curReq = "R8";
    idleN(1);
    curReq = "R9";
    wrSmp(16'hC3D4);
    wrSmp(16'hE5F6);
    curReq = "R8";
    wrCtl(16'h003F);
    wrCtl(16'h0000);
    idleN(2);

    // R5: read clears while level is high
    curReq = "R5";
    rdCtl();
    idleN(2);

    // R6: software post, then a zero write keeps it
    curReq = "R6";
    wrCtl(16'h0080);
    wrCtl(16'h0000);
    idleN(1);

    // R7: enable shows flag on irqOut; flag pollable when disabled
    curReq = "R7";
    wrCtl(16'h0040);
    idleN(1);
    rdCtl();
    idleN(1);
    wrCtl(16'h0080);
    wrCtl(16'h0000);
    idleN(1);

    // R10: drain in order, then pop an empty queue
    curReq = "R10";
    for (int i = 0; i < 5; i++) popOne();
    idleN(1);

    // R5: read while low; set wins
    curReq = "R5";
    rdCtl();
    idleN(1);

    // R11: push and pop together at level 2 and level 1
    curReq = "R11";
    wrSmp(16'h1122);
    idle(); regSel = 1; wrEn = 1; wrData = 16'h3344; periodEnd = 1; step(); idle();
    idleN(1);
    popOne(); popOne();
    idle(); regSel = 1; wrEn = 1; wrData = 16'h5566; periodEnd = 1; step(); idle();
    idle(); regSel = 1; wrEn = 1; wrData = 16'h7788; periodEnd = 1; step(); idle();
    for (int i = 0; i < 5; i++) popOne();

    // R3: divide by 3 on system strobe, restart on change, no restart on same value
    curReq = "R3";
    wrCtl(16'h0200);
    idle(); sysTick = 1;
    for (int i = 0; i < 7; i++) step();
    regSel = 0; wrEn = 1; wrData = 16'h0300; step(); wrEn = 0;
    for (int i = 0; i < 6; i++) step();
    regSel = 0; wrEn = 1; wrData = 16'h0300; step(); wrEn = 0;
    for (int i = 0; i < 6; i++) step();
    wrCtl(16'h0000);
    idle(); sysTick = 1;
    for (int i = 0; i < 4; i++) step();

    // R2: slow source selected, system strobe ignored
    curReq = "R2";
    wrCtl(16'h8100);
    for (int i = 0; i < 12; i++) begin
      idle(); sysTick = 1; slowTick = (i % 3 == 0); step();
    end
    wrCtl(16'h0100);
    for (int i = 0; i < 6; i++) begin
      idle(); sysTick = (i % 2 == 0); slowTick = 1; step();
    end

    // R4: random mix compared every clock
    curReq = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = int'($urandom_range(0, 99));
      regSel    = r < 35;
      wrEn      = (r < 35) || (r >= 90 && r < 94);
      rdEn      = (r >= 80 && r < 90);
      wrData    = 16'($urandom);
      if (!regSel && wrEn) wrData[14:10] = '0;
      periodEnd = $urandom_range(0, 2) == 0;
      sysTick   = $urandom_range(0, 1) == 1;
      slowTick  = $urandom_range(0, 4) == 0;
      step();
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule